// File: doc/BRIEF.md
# Snapshot-Read Tick Counter with Armed Preset

The block keeps a 48-bit count that moves forward once for every rising edge of a slow 32.768 kHz tick input. The count is stored as six 8-bit bytes. Software on a faster bus clock never reads the live count. It first writes to the lowest holding address, which copies all six bytes in one bus clock edge. It then reads the six frozen bytes one address at a time. The count keeps running during the read, and every copy comes from a single edge, so a read sequence never mixes old and new bytes.

The count cannot be written directly. To preset it, software writes an arm code and then a clear code to a command address. One clear code also opens an increment mode. In that mode each command steps any chosen set of bytes by one, and the steps do not carry between bytes. Any 48-bit value can therefore be reached with at most 255 steps per byte. The slow tick is synchronised into the bus clock domain and reduced to a single-cycle pulse before it reaches the counter.

Top module: `tick_snap_counter`

## Requirements
- R1: After reset the count and all six holding bytes are 0x00, and the command logic is neither armed nor in increment mode.
- R2: On the third bus clock edge after `tickAsync` is first sampled high, the count goes up by one. Carries run through all six bytes, and 0xFFFFFFFFFFFF wraps to 0. A tick input that stays high gives only one step.
- R3: A write of any data to address 1 copies the live count into the holding bytes at that edge, and counting goes on. Without such a write the holding bytes keep their value.
- R4: A read of address 1+k returns holding byte k for k = 0..5, with byte 0 the least significant. Addresses 0 and 7 read 0x00.
- R5: Writes to addresses 2 to 6 change neither the count nor the holding bytes.
- R6: A write of 0x40 to address 0 arms the logic. If the next command write is 0x80, all six count bytes become 0x00 and the logic returns to idle.
- R7: A 0x80 or 0xC0 written when the logic is not armed is ignored. The next command write of any value uses up the arm, so an arm that is followed by 0x00, 0x40 or 0x41 and then 0x80 does not clear.
- R8: When armed, 0xC0 clears the count and enters increment mode. In that mode a command 01mmmmmm (bits 7:6 = 01) adds one to every byte k whose bit k of m is 1. A byte wraps from 0xFF to 0x00 and does not carry into the next byte. The code 0x40 (empty mask) keeps the mode.
- R9: In increment mode 0x00 leaves the mode, and after that 01mmmmmm commands are ignored. The clear done by 0xC0 is not undone. Outside increment mode 01mmmmmm never steps any byte.
- R10: In increment mode a command whose bit 7 is 1 (for example 0x80 or 0xC5) is ignored and the mode stays on.
- R11: If a tick and a byte step fall on the same edge, that byte gains both. If a clear and a tick fall on the same edge, the count becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickAsync | input | 1 | 32.768 kHz tick input, not synchronised to clk |
| busWrEn | input | 1 | Write strobe for busAddr and busWrData |
| busAddr | input | 3 | Register address: 0 is the command, 1 to 6 are holding bytes 0 to 5 |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr, combinational from the holding bytes |

## Verification
The bench uses the default parameters: two synchroniser stages, six bytes of eight bits, and a three-bit address. With two stages the tick latency is exactly three edges. This lets the bench place a byte step or a clear on the very edge where a tick lands. Presets built from 255 single steps per byte reach a carry across two full bytes and the full 48-bit wrap in a few thousand cycles, although reaching them by counting would take 2^48 ticks.

// File: rtl/tick_snap_pkg.sv
`timescale 1ns/1ps
package tick_snap_pkg;
  localparam int BYTE_W  = 8;
  localparam int N_BYTES = 6;
  localparam int ADDR_W  = 3;

  localparam logic [ADDR_W-1:0] ADDR_CMD   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_HOLD0 = 3'd1;

  localparam logic [BYTE_W-1:0] CMD_ARM     = 8'h40;
  localparam logic [BYTE_W-1:0] CMD_CLR     = 8'h80;
  localparam logic [BYTE_W-1:0] CMD_CLR_INC = 8'hC0;
  localparam logic [BYTE_W-1:0] CMD_EXIT    = 8'h00;

  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_INC} cmdState_t;

  typedef struct packed {
    logic               tick;
    logic               clear;
    logic               snap;
    logic [N_BYTES-1:0] incMask;
  } ctrlStrobe_t;
endpackage

// File: rtl/tick_cmd_ctrl.sv
`timescale 1ns/1ps
module tick_cmd_ctrl
  import tick_snap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickAsync,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  output ctrlStrobe_t       strb
);
  logic [SYNC_STAGES:0] syncQ;
  cmdState_t state, stateNext;
  logic cmdWr, incField, clearNow;
  logic [N_BYTES-1:0] maskNow;

  // synchroniser plus one edge-detect stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], tickAsync};
  end

  assign cmdWr    = wrEn && (wrAddr == ADDR_CMD);
  assign incField = (wrData[BYTE_W-1:BYTE_W-2] == 2'b01);

  always_comb begin
    stateNext = state;
    clearNow  = 1'b0;
    maskNow   = '0;
    if (cmdWr) begin
      unique case (state)
        ST_IDLE:  if (wrData == CMD_ARM) stateNext = ST_ARMED;
        ST_ARMED: begin
          stateNext = ST_IDLE;
          if (wrData == CMD_CLR) clearNow = 1'b1;
          else if (wrData == CMD_CLR_INC) begin
            clearNow  = 1'b1;
            stateNext = ST_INC;
          end
        end
        ST_INC: begin
          if (wrData == CMD_EXIT) stateNext = ST_IDLE;
          else if (incField)      maskNow   = wrData[N_BYTES-1:0];
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign strb.tick    = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];
  assign strb.clear   = clearNow;
  assign strb.snap    = wrEn && (wrAddr == ADDR_HOLD0);
  assign strb.incMask = maskNow;

  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.tick |=> !strb.tick);
  // R7
  clear_needs_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |-> $past(stateNext) == ST_ARMED || state == ST_ARMED);
  // R9
  inc_only_in_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incMask != '0) |=> state == ST_INC);
endmodule

// File: rtl/tick_count_path.sv
`timescale 1ns/1ps
module tick_count_path
  import tick_snap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BYTE_W-1:0] rdData
);
  localparam int CNT_W = BYTE_W * N_BYTES;

  logic [BYTE_W-1:0] cntByte  [N_BYTES];
  logic [BYTE_W-1:0] holdByte [N_BYTES];
  logic [N_BYTES-1:0] lowerFull;
  logic [CNT_W-1:0] liveFlat, holdFlat;
  logic [ADDR_W-1:0] rdIdx;

  for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
    logic carryIn;
    if (b == 0) begin : g_first
      assign lowerFull[b] = 1'b1;
    end else begin : g_upper
      assign lowerFull[b] = lowerFull[b-1] & (&cntByte[b-1]);
    end
    assign carryIn = strb.tick & lowerFull[b];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntByte[b]  <= '0;
        holdByte[b] <= '0;
      end else begin
        if (strb.clear) cntByte[b] <= '0;
        else cntByte[b] <= cntByte[b] + BYTE_W'(carryIn) + BYTE_W'(strb.incMask[b]);
        if (strb.snap) holdByte[b] <= cntByte[b];
      end
    end

    assign liveFlat[b*BYTE_W +: BYTE_W] = cntByte[b];
    assign holdFlat[b*BYTE_W +: BYTE_W] = holdByte[b];
  end

  assign rdIdx  = rdAddr - ADDR_HOLD0;
  assign rdData = (rdAddr >= ADDR_HOLD0 && rdIdx < ADDR_W'(N_BYTES)) ? holdByte[rdIdx] : '0;

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> liveFlat == '0);
  // R3
  snap_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.snap |=> holdFlat == $past(liveFlat));
  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.snap |=> $stable(holdFlat));
  // R5
  count_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tick && !strb.clear && strb.incMask == '0) |=> $stable(liveFlat));
endmodule

// File: rtl/tick_snap_counter.sv
`timescale 1ns/1ps
module tick_snap_counter
  import tick_snap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickAsync,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWrData,
  output logic [BYTE_W-1:0] busRdData
);
  ctrlStrobe_t strb;

  tick_cmd_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .tickAsync(tickAsync),
    .wrEn(busWrEn), .wrAddr(busAddr), .wrData(busWrData), .strb(strb)
  );

  tick_count_path path_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rdAddr(busAddr), .rdData(busRdData)
  );
endmodule

// File: tb/tick_snap_counter_tb_top.sv
`timescale 1ns/1ps
module tick_snap_counter_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickAsync = 1'b0;
  logic busWrEn = 1'b0;
  logic [2:0] busAddr = 3'd0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;

  int nChecks = 0;
  int nErr = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tick_snap_counter dut_i (
    .clk(clk), .rstN(rstN), .tickAsync(tickAsync), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData)
  );

  // behavioural reference model
  logic [7:0] mCnt [6];
  logic [7:0] mHold [6];
  logic [7:0] oldCnt [6];
  int mState;
  bit mHist [3];
  bit tk, clr, full;
  logic [5:0] inc;
  int add;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < 6; b++) begin mCnt[b] = 0; mHold[b] = 0; end
      mState = 0;
      mHist[0] = 0; mHist[1] = 0; mHist[2] = 0;
    end else begin
      tk = mHist[1] && !mHist[2];
      mHist[2] = mHist[1]; mHist[1] = mHist[0]; mHist[0] = tickAsync;
      clr = 0; inc = 0;
      if (busWrEn && busAddr == 0) begin
        if (mState == 0) begin
          if (busWrData == 8'h40) mState = 1;
        end else if (mState == 1) begin
          mState = 0;
          if (busWrData == 8'h80) clr = 1;
          else if (busWrData == 8'hC0) begin clr = 1; mState = 2; end
        end else begin
          if (busWrData == 8'h00) mState = 0;
          else if (busWrData[7:6] == 2'b01) inc = busWrData[5:0];
        end
      end
      for (int b = 0; b < 6; b++) oldCnt[b] = mCnt[b];
      full = 1;
      for (int b = 0; b < 6; b++) begin
        add = ((tk && full) ? 1 : 0) + (inc[b] ? 1 : 0);
        mCnt[b] = clr ? 8'h00 : 8'(oldCnt[b] + add);
        full = full && (oldCnt[b] == 8'hFF);
      end
      if (busWrEn && busAddr == 1)
        for (int b = 0; b < 6; b++) mHold[b] = oldCnt[b];
    end
  end

  // per-clock comparison of the read port against the model (R4)
  always @(negedge clk) begin
    logic [7:0] expRd;
    #1;
    if (rstN && !finished) begin
      expRd = (busAddr >= 1 && busAddr <= 6) ? mHold[busAddr-1] : 8'h00;
      nChecks++;
      if (busRdData !== expRd) begin
        nErr++;
        $display("FAIL R4 model compare addr=%0d got=%h exp=%h", busAddr, busRdData, expRd);
      end
    end
  end

  task automatic check(input string req, input logic [47:0] got, input logic [47:0] exp);
    nChecks++;
    if (got !== exp) begin
      nErr++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] d);
    busWrite(3'd0, d);
  endtask

  task automatic cmdRepeat(input logic [7:0] d, input int n);
    for (int i = 0; i < n; i++) cmd(d);
  endtask

  task automatic readHold(output logic [47:0] v);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      busAddr = 3'(k);
      #1 v[(k-1)*8 +: 8] = busRdData;
    end
  endtask

  task automatic snapRead(output logic [47:0] v);
    busWrite(3'd1, 8'h5C);
    readHold(v);
  endtask

  task automatic tickOnce();
    @(negedge clk); tickAsync = 1'b1;
    repeat (3) @(negedge clk);
    tickAsync = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic tickWithCmd(input logic [7:0] d);
    @(negedge clk); tickAsync = 1'b1;
    @(negedge clk);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = 3'd0; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
    repeat (4) @(negedge clk);
    tickAsync = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [47:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    readHold(v);            check("R1 holding after reset", v, 48'h0);
    snapRead(v);            check("R1 count after reset", v, 48'h0);

    for (int i = 0; i < 5; i++) tickOnce();
    snapRead(v);            check("R2 five ticks", v, 48'd5);

    tickOnce(); tickOnce();
    readHold(v);            check("R3 holding stable without snapshot", v, 48'd5);
    snapRead(v);            check("R3 new snapshot", v, 48'd7);

    cmd(8'h40); cmd(8'h80);
    snapRead(v);            check("R6 armed clear", v, 48'h0);

    cmd(8'h40); cmd(8'hC0);
    cmdRepeat(8'h41, 255); cmdRepeat(8'h42, 2);
    snapRead(v);            check("R8 byte steps", v, 48'h02FF);
    cmd(8'h41);
    snapRead(v);            check("R8 byte wrap without carry", v, 48'h0200);
    cmd(8'h4D);
    snapRead(v);            check("R8 mask 0x4D", v, 48'h000001010201);

    cmd(8'h80); cmd(8'hC5); cmd(8'h40); cmd(8'h42);
    snapRead(v);            check("R10 ignored codes keep mode", v, 48'h000001010301);

    tickWithCmd(8'h41);
    snapRead(v);            check("R11 tick and step same edge", v, 48'h000001010303);

    cmd(8'h00); cmd(8'h41);
    snapRead(v);            check("R9 step after exit ignored", v, 48'h000001010303);

    cmd(8'h80);
    snapRead(v);            check("R7 clear without arm", v, 48'h000001010303);
    cmd(8'h40); cmd(8'h00); cmd(8'h80);
    snapRead(v);            check("R7 arm consumed by 0x00", v, 48'h000001010303);
    cmd(8'h40); cmd(8'h41); cmd(8'h80);
    snapRead(v);            check("R7 arm consumed by 0x41", v, 48'h000001010303);
    cmd(8'hC0);
    snapRead(v);            check("R7 0xC0 without arm", v, 48'h000001010303);

    cmd(8'h40); cmd(8'hC0); cmd(8'h00); cmd(8'h41);
    snapRead(v);            check("R9 clear kept after exit", v, 48'h0);

    cmd(8'h40); cmd(8'hC0); cmdRepeat(8'h43, 255); cmd(8'h00);
    snapRead(v);            check("R8 preset 0xFFFF", v, 48'hFFFF);
    tickOnce();
    snapRead(v);            check("R2 carry across two bytes", v, 48'h10000);

    busWrite(3'd3, 8'hAA); busWrite(3'd6, 8'h55);
    readHold(v);            check("R5 holding after byte writes", v, 48'h10000);
    snapRead(v);            check("R5 count after byte writes", v, 48'h10000);

    @(negedge clk); busAddr = 3'd0; #1 check("R4 address 0 reads zero", {40'h0, busRdData}, 48'h0);
    @(negedge clk); busAddr = 3'd7; #1 check("R4 address 7 reads zero", {40'h0, busRdData}, 48'h0);

    cmd(8'h40);
    tickWithCmd(8'h80);
    snapRead(v);            check("R11 clear wins over tick", v, 48'h0);

    cmd(8'h40); cmd(8'hC0); cmdRepeat(8'h7F, 255);
    snapRead(v);            check("R8 all bytes 0xFF", v, 48'hFFFFFFFFFFFF);
    cmd(8'h00);
    tickOnce();
    snapRead(v);            check("R2 full wrap", v, 48'h0);

    @(negedge clk); tickAsync = 1'b1;
    repeat (12) @(negedge clk);
    snapRead(v);            check("R2 held tick steps once", v, 48'd1);
    tickAsync = 1'b0;

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nErr++;
      $display("FAIL watchdog expired got=hung exp=done");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end
endmodule